// File: doc/BRIEF.md
# Companded PCM Serial Port

This block is the full-duplex serial front end for a voice path that carries 8-bit mu-law samples. Two serial lanes come in: send-in and receive-in. Two serial lanes go out: send-out and receive-out. All four share one bit clock and one 8 kHz frame sync.

On each frame the port shifts in one byte per input lane. When both bytes are complete, it presents them on parallel buses and pulses an active-low load-detect strobe for one system clock. That strobe starts the frame's processing elsewhere, and in a single-device setup it is simply fed back as the frame interrupt.

In the same frame the port shifts out the two processed bytes handed to it. Each output lane's enable is high only for the eight bit times of its slot, so outside the slot the pin is released to high impedance. The port can use an external bit clock and sync. It can also make its own from the system clock: by default it divides by 90, which gives about 200 kHz from 18 MHz, and uses 25 bit times per frame to reach 8 kHz.

All serial inputs are synchronised into the system clock domain and their edges are detected there. This requires a system clock well above twice the highest bit rate. The mu-law conversion and the echo processing are outside this block.

Top module: `pcm_serial_port`

## Requirements
- R1: Both input lanes are sampled on falling bit-clock edges, MSB (bit 7) first down to bit 0. A byte starts at the first falling edge that sees sync high when the previous falling edge saw sync low; the next seven falling edges supply bits 6 to 0.
- R2: After the eighth bit, both captured bytes appear on `sin_word`/`rin_word` in the same cycle as `ld_n` goes low. `ld_n` is low for exactly one system clock per frame. The bytes then hold until the next such pulse.
- R3: Each output lane drives its byte MSB first. The byte is taken from `sout_word`/`rout_word` at the rising bit-clock edge that first sees sync high, and bit 7 is driven from that edge. Each later rising edge moves to the next lower bit.
- R4: `sout_oe`/`rout_oe` are high for exactly the eight bit times of the slot. They drop at the ninth rising edge and are low whenever no data bit is driven.
- R5: With `sel_int` high, the generated `bclk_out` has a period of 2*HALF_DIV system clocks (90 by default) and a 50 % duty.
- R6: The generated `fsync_out` rises together with `bclk_out` and stays high for 8 bit periods (720 clocks). It repeats every FRAME_BITS bit periods (2250 clocks by default).
- R7: With `sel_int` high, the port frames its transfers on the generated clock and sync, and activity on `ext_bclk`/`ext_fsync` has no effect.
- R8: While `pwr_dn` is high, `bclk_out` and `fsync_out` are held low, both output enables are low, and no load-detect pulse occurs.
- R9: After a synchronous reset (`rst_n` low), both output enables are low, `ld_n` is high, the captured words are 0 and the generated clock and sync are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn | input | 1 | Power-down, active high |
| sel_int | input | 1 | 1: use generated bit clock and sync; 0: use external ones |
| ext_bclk | input | 1 | External bit clock |
| ext_fsync | input | 1 | External long-frame sync |
| sin_ser | input | 1 | Send-in serial data |
| rin_ser | input | 1 | Receive-in serial data |
| sout_word | input | 8 | Processed byte to send on send-out |
| rout_word | input | 8 | Processed byte to send on receive-out |
| sout_ser | output | 1 | Send-out serial data (valid while `sout_oe`) |
| sout_oe | output | 1 | Send-out drive enable; low means high impedance |
| rout_ser | output | 1 | Receive-out serial data (valid while `rout_oe`) |
| rout_oe | output | 1 | Receive-out drive enable; low means high impedance |
| sin_word | output | 8 | Last captured send-in byte |
| rin_word | output | 8 | Last captured receive-in byte |
| ld_n | output | 1 | Active-low one-cycle load-detect strobe |
| bclk_out | output | 1 | Generated bit clock |
| fsync_out | output | 1 | Generated frame sync |

## Verification
The assertions check several properties on every cycle:
- the load-detect strobe never lasts more than one clock;
- the captured words never change without that strobe;
- power-down silences the generated clocks, enables and strobe;
- the generated sync only rises together with the bit clock;
- the generated bit clock never gives a single-cycle high pulse.

Other behaviour only the bench scenarios can show: bit order, slot start and the exact enable window, the values captured and sent across a full sweep of byte values, and the generated periods. The bench also shows that the external pins are ignored in internal mode.

// File: rtl/pcm_port_pkg.sv
// Shared definitions for the companded PCM serial port.
package pcm_port_pkg;

    // Bit-clock events seen in the system clock domain, with the aligned sync level.
    typedef struct packed {
        logic rise;
        logic fall;
        logic fs;
    } bclk_ev_t;

    // Bits needed to hold a count from 0 to n inclusive.
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pcm_clkgen.sv
// Bit clock and frame sync generator.
// Divides the system clock by 2*HALF_DIV to make the bit clock. The sync is
// raised together with the bit clock for SLOT_BITS bit periods of every
// FRAME_BITS. Assumes HALF_DIV >= 2 and FRAME_BITS > SLOT_BITS. Holds both
// outputs low while clr is high.
module pcm_clkgen #(
    parameter int HALF_DIV   = 45,
    parameter int FRAME_BITS = 25,
    parameter int SLOT_BITS  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic bclk,
    output logic fsync
);
    localparam int DW = pcm_port_pkg::cnt_bits(HALF_DIV - 1);
    localparam int IW = pcm_port_pkg::cnt_bits(FRAME_BITS - 1);
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_BITS - 1);
    localparam logic [IW-1:0] SLOT_END = IW'(SLOT_BITS);

    logic [DW-1:0] div_q;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] idx_nx;
    logic          bclk_q;
    logic          fs_q;

    // Next bit index within the frame, taken at each rising edge.
    always_comb idx_nx = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;

    // Divider, bit clock toggle, and sync update on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            div_q  <= '0;
            bclk_q <= 1'b0;
            idx_q  <= IDX_LAST;
            fs_q   <= 1'b0;
        end else if (div_q == DIV_LAST) begin
            div_q  <= '0;
            bclk_q <= ~bclk_q;
            if (!bclk_q) begin
                idx_q <= idx_nx;
                fs_q  <= (idx_nx < SLOT_END);
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign bclk  = bclk_q;
    assign fsync = fs_q;
endmodule

// File: rtl/pcm_edge_front.sv
// Synchroniser and edge detector for the serial side.
// Passes bit clock, sync and all data lanes through the same STAGES-deep
// flop chain, so they stay aligned. It then flags rising and falling
// bit-clock edges. Assumes the system clock is well above twice the bit rate.
module pcm_edge_front
    import pcm_port_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int NDATA  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bclk_raw,
    input  logic             fs_raw,
    input  logic [NDATA-1:0] data_raw,
    output bclk_ev_t         ev,
    output logic [NDATA-1:0] data_s
);
    localparam int NB = NDATA + 2;

    logic [NB-1:0] sh [STAGES];
    logic [NB-1:0] last;
    logic          bclk_d;

    // First synchroniser stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sh[0] <= '0;
        else               sh[0] <= {data_raw, fs_raw, bclk_raw};
    end

    // Remaining synchroniser stages.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n || clr) sh[g] <= '0;
            else               sh[g] <= sh[g-1];
        end
    end

    assign last = sh[STAGES-1];

    // Delayed bit clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) bclk_d <= 1'b0;
        else               bclk_d <= last[0];
    end

    assign ev.rise = last[0] & ~bclk_d;
    assign ev.fall = ~last[0] & bclk_d;
    assign ev.fs   = last[1];
    assign data_s  = last[NB-1:2];
endmodule

// File: rtl/pcm_rx_lane.sv
// One input lane.
// Shifts a serial bit in, MSB first, on each shift strobe. Copies the full
// byte to the held output on load. The held byte is cleared only by reset.
module pcm_rx_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    input  logic         load,
    output logic [W-1:0] word
);
    logic [W-1:0] sh_q;
    logic [W-1:0] word_q;

    // Input shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sh_q <= '0;
        else if (shift)    sh_q <= {sh_q[W-2:0], din};
    end

    // Held copy, presented to the processing side.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= sh_q;
    end

    assign word = word_q;
endmodule

// File: rtl/pcm_tx_lane.sv
// One output lane.
// Latches the byte on start and drives its MSB. Moves one bit lower on each
// shift. Releases the lane (oe low) on stop or clr.
module pcm_tx_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         start,
    input  logic         shift,
    input  logic         stop,
    input  logic [W-1:0] word_in,
    output logic         dout,
    output logic         oe
);
    logic [W-1:0] sh_q;
    logic         oe_q;

    // Output shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sh_q <= '0;
        else if (start)    sh_q <= word_in;
        else if (shift)    sh_q <= {sh_q[W-2:0], 1'b0};
    end

    // Drive enable: high for the slot only.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) oe_q <= 1'b0;
        else if (start)    oe_q <= 1'b1;
        else if (stop)     oe_q <= 1'b0;
    end

    assign dout = oe_q & sh_q[W-1];
    assign oe   = oe_q;
endmodule

// File: rtl/pcm_serial_port.sv
// Full-duplex serial port for 8-bit companded voice samples.
// Captures send-in and receive-in bytes on falling bit-clock edges and
// strobes ld_n once both are held. Sends two bytes on rising edges, with
// the drive enables confined to the 8-bit slot. Assumes a long-frame sync,
// whose first edge seen high marks the MSB. Clock and sync come from the
// external pins or from the internal generator, as sel_int selects.
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int HALF_DIV    = 45,
    parameter int FRAME_BITS  = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_dn,
    input  logic                sel_int,
    input  logic                ext_bclk,
    input  logic                ext_fsync,
    input  logic                sin_ser,
    input  logic                rin_ser,
    input  logic [SAMPLE_W-1:0] sout_word,
    input  logic [SAMPLE_W-1:0] rout_word,
    output logic                sout_ser,
    output logic                sout_oe,
    output logic                rout_ser,
    output logic                rout_oe,
    output logic [SAMPLE_W-1:0] sin_word,
    output logic [SAMPLE_W-1:0] rin_word,
    output logic                ld_n,
    output logic                bclk_out,
    output logic                fsync_out
);
    localparam int LANES = 2;
    localparam int CW    = cnt_bits(SAMPLE_W);
    localparam logic [CW-1:0] CNT_FULL = CW'(SAMPLE_W);

    logic                             gen_bclk, gen_fs;
    logic                             bclk_mux, fs_mux;
    bclk_ev_t                         ev;
    logic [LANES-1:0]                 ser_in, ser_s;
    logic [LANES-1:0][SAMPLE_W-1:0]   tx_words, rx_words;
    logic [LANES-1:0]                 tx_dout, tx_oe;
    logic                             fs_fall_q, fs_rise_q;
    logic [CW-1:0]                    rx_cnt, tx_cnt;
    logic                             rx_start, rx_shift, rx_load;
    logic                             tx_start, tx_shift, tx_stop;
    logic                             ld_q;

    pcm_clkgen #(
        .HALF_DIV  (HALF_DIV),
        .FRAME_BITS(FRAME_BITS),
        .SLOT_BITS (SAMPLE_W)
    ) u_gen (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (pwr_dn),
        .bclk (gen_bclk),
        .fsync(gen_fs)
    );

    assign bclk_mux = sel_int ? gen_bclk : ext_bclk;
    assign fs_mux   = sel_int ? gen_fs   : ext_fsync;
    assign ser_in   = {rin_ser, sin_ser};
    assign tx_words = {rout_word, sout_word};

    pcm_edge_front #(
        .STAGES(SYNC_STAGES),
        .NDATA (LANES)
    ) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pwr_dn),
        .bclk_raw(bclk_mux),
        .fs_raw  (fs_mux),
        .data_raw(ser_in),
        .ev      (ev),
        .data_s  (ser_s)
    );

    // Receive slot control: start on sync newly high at a falling edge.
    assign rx_start = ev.fall & ev.fs & ~fs_fall_q;
    assign rx_shift = rx_start | (ev.fall & (rx_cnt != '0) & (rx_cnt < CNT_FULL));
    assign rx_load  = (rx_cnt == CNT_FULL);

    // Receive bit counter and the sync level seen at the last falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn) begin
            fs_fall_q <= 1'b0;
            rx_cnt    <= '0;
        end else begin
            if (ev.fall) fs_fall_q <= ev.fs;
            if (rx_load)       rx_cnt <= '0;
            else if (rx_start) rx_cnt <= CW'(1);
            else if (rx_shift) rx_cnt <= rx_cnt + 1'b1;
        end
    end

    // Load-detect strobe, aligned with the held words changing.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn) ld_q <= 1'b0;
        else                  ld_q <= rx_load;
    end

    // Transmit slot control: start on sync newly high at a rising edge.
    assign tx_start = ev.rise & ev.fs & ~fs_rise_q;
    assign tx_shift = ev.rise & ~tx_start & (tx_cnt != '0) & (tx_cnt < CNT_FULL);
    assign tx_stop  = ev.rise & ~tx_start & (tx_cnt == CNT_FULL);

    // Transmit bit counter and the sync level seen at the last rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn) begin
            fs_rise_q <= 1'b0;
            tx_cnt    <= '0;
        end else begin
            if (ev.rise) fs_rise_q <= ev.fs;
            if (tx_start)      tx_cnt <= CW'(1);
            else if (tx_shift) tx_cnt <= tx_cnt + 1'b1;
            else if (tx_stop)  tx_cnt <= '0;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        pcm_rx_lane #(.W(SAMPLE_W)) u_rx (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (pwr_dn),
            .shift(rx_shift),
            .din  (ser_s[l]),
            .load (rx_load & ~pwr_dn),
            .word (rx_words[l])
        );
        pcm_tx_lane #(.W(SAMPLE_W)) u_tx (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (pwr_dn),
            .start  (tx_start),
            .shift  (tx_shift),
            .stop   (tx_stop),
            .word_in(tx_words[l]),
            .dout   (tx_dout[l]),
            .oe     (tx_oe[l])
        );
    end

    assign sin_word  = rx_words[0];
    assign rin_word  = rx_words[1];
    assign sout_ser  = tx_dout[0];
    assign sout_oe   = tx_oe[0];
    assign rout_ser  = tx_dout[1];
    assign rout_oe   = tx_oe[1];
    assign ld_n      = ~ld_q;
    assign bclk_out  = gen_bclk;
    assign fsync_out = gen_fs;
endmodule

// File: rtl/pcm_port_checker.sv
// Cycle-level properties of the serial port, bound onto every instance.
module pcm_port_checker #(
    parameter int SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pwr_dn,
    input logic                ld_n,
    input logic [SAMPLE_W-1:0] sin_word,
    input logic [SAMPLE_W-1:0] rin_word,
    input logic                sout_oe,
    input logic                rout_oe,
    input logic                bclk_out,
    input logic                fsync_out
);
    // R2: the strobe lasts one clock only.
    a_r2_ld_single: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> ld_n);

    // R2: held words change only together with the strobe.
    a_r2_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |-> ($stable(sin_word) && $stable(rin_word)));

    // R8: power-down silences generator, enables and strobe.
    a_r8_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!bclk_out && !fsync_out && !sout_oe && !rout_oe && ld_n));

    // R6: generated sync rises only with the generated bit clock.
    a_r6_sync_on_bclk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync_out) |-> $rose(bclk_out));

    // R5: generated bit clock is never high for a single cycle.
    a_r5_bclk_width: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
        $rose(bclk_out) |=> bclk_out);
endmodule

bind pcm_serial_port pcm_port_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .ld_n     (ld_n),
    .sin_word (sin_word),
    .rin_word (rin_word),
    .sout_oe  (sout_oe),
    .rout_oe  (rout_oe),
    .bclk_out (bclk_out),
    .fsync_out(fsync_out)
);

// File: tb/sim_pcm_serial_port.sv
// Self-checking bench: sweeps all send-in byte values over the external
// clock, then measures the generator and runs frames on it, then power-down.
module sim_pcm_serial_port;
    localparam int HB = 8;          // external half bit time, system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       sel_int = 1'b0;
    logic       ext_bclk = 1'b0;
    logic       ext_fsync = 1'b0;
    logic       sin_ser = 1'b0;
    logic       rin_ser = 1'b0;
    logic [7:0] sout_word = 8'h00;
    logic [7:0] rout_word = 8'h00;
    logic       sout_ser, sout_oe, rout_ser, rout_oe, ld_n, bclk_out, fsync_out;
    logic [7:0] sin_word, rin_word;

    int checks = 0;
    int errors = 0;
    int ld_cnt = 0;
    int cycles = 0;

    pcm_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .sel_int(sel_int),
        .ext_bclk(ext_bclk), .ext_fsync(ext_fsync),
        .sin_ser(sin_ser), .rin_ser(rin_ser),
        .sout_word(sout_word), .rout_word(rout_word),
        .sout_ser(sout_ser), .sout_oe(sout_oe),
        .rout_ser(rout_ser), .rout_oe(rout_oe),
        .sin_word(sin_word), .rin_word(rin_word),
        .ld_n(ld_n), .bclk_out(bclk_out), .fsync_out(fsync_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    always @(negedge clk) if (rst_n && !ld_n) ld_cnt++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog act=%0d exp<=150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Two idle bits, an 8-bit slot, two trailing bits on the external clock.
    task automatic ext_frame(input logic [7:0] sb, rb, ts, tr);
        logic [7:0] gs, gr;
        int l0, oe_bad;
        gs = '0; gr = '0; oe_bad = 0;
        sout_word = ts; rout_word = tr; l0 = ld_cnt;
        for (int i = 0; i < 12; i++) begin
            int b;
            b = i - 2;
            ext_bclk  = 1'b1;
            ext_fsync = (b >= 0 && b < 8);
            sin_ser   = (b >= 0 && b < 8) ? sb[7-b] : 1'b0;
            rin_ser   = (b >= 0 && b < 8) ? rb[7-b] : 1'b0;
            repeat (HB) @(negedge clk);
            ext_bclk = 1'b0;
            repeat (HB/2) @(negedge clk);
            if (b >= 0 && b < 8) begin
                if (!sout_oe || !rout_oe) oe_bad++;
                gs[7-b] = sout_ser; gr[7-b] = rout_ser;
            end else if (sout_oe || rout_oe) oe_bad++;
            repeat (HB/2) @(negedge clk);
        end
        chk(sin_word == sb, "R1 send-in byte", sin_word, sb);
        chk(rin_word == rb, "R1 receive-in byte", rin_word, rb);
        chk(ld_cnt - l0 == 1, "R2 one strobe per frame", ld_cnt - l0, 1);
        chk(gs == ts, "R3 send-out bits", gs, ts);
        chk(gr == tr, "R3 receive-out bits", gr, tr);
        chk(oe_bad == 0, "R4 enable window", oe_bad, 0);
    endtask

    // One frame on the generated clock, with noise on the external pins (R7).
    task automatic int_frame(input logic [7:0] sb, rb, ts, tr);
        logic [7:0] gs, gr;
        logic pf, pb;
        int l0, oe_bad, bitn;
        gs = '0; gr = '0; oe_bad = 0;
        sout_word = ts; rout_word = tr;
        pf = 1'b1;
        while (!( !pf && fsync_out)) begin
            pf = fsync_out;
            @(negedge clk);
        end
        l0 = ld_cnt; bitn = 0; pb = 1'b1;
        sin_ser = sb[7]; rin_ser = rb[7];
        for (int c = 0; c < 900; c++) begin
            @(negedge clk);
            ext_bclk = c[2]; ext_fsync = c[4];
            if (!pb && bclk_out) begin
                bitn++;
                sin_ser = (bitn < 8) ? sb[7-bitn] : 1'b0;
                rin_ser = (bitn < 8) ? rb[7-bitn] : 1'b0;
            end
            if (pb && !bclk_out) begin
                if (bitn < 8) begin
                    if (!sout_oe || !rout_oe) oe_bad++;
                    gs[7-bitn] = sout_ser; gr[7-bitn] = rout_ser;
                end else if (sout_oe || rout_oe) oe_bad++;
            end
            pb = bclk_out;
        end
        ext_bclk = 1'b0; ext_fsync = 1'b0;
        chk(sin_word == sb && rin_word == rb, "R7 internal capture", {sin_word, rin_word}, {sb, rb});
        chk(ld_cnt - l0 == 1, "R7 internal strobe count", ld_cnt - l0, 1);
        chk(gs == ts && gr == tr, "R7 internal send bits", {gs, gr}, {ts, tr});
        chk(oe_bad == 0, "R7 internal enable window", oe_bad, 0);
    endtask

    initial begin
        int n, bad, l0;
        logic pv;
        repeat (10) @(negedge clk);
        // R9 reset state
        chk(!sout_oe && !rout_oe, "R9 enables low in reset", {sout_oe, rout_oe}, 0);
        chk(ld_n, "R9 strobe idle", ld_n, 1);
        chk(sin_word == 0 && rin_word == 0, "R9 words cleared", {sin_word, rin_word}, 0);
        chk(!bclk_out && !fsync_out, "R9 generator low", {bclk_out, fsync_out}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1..R4 sweep over every send-in byte value
        for (int k = 0; k < 256; k++)
            ext_frame(8'(k), 8'((255 - k) ^ 8'h5A), 8'(k * 7 + 3), 8'(k ^ 8'hC3));

        // R5 bit clock period
        sel_int = 1'b1;
        pv = bclk_out;
        while (!(!pv && bclk_out)) begin pv = bclk_out; @(negedge clk); end
        n = 0; pv = 1'b1;
        do begin pv = bclk_out; @(negedge clk); n++; end while (!(!pv && bclk_out));
        chk(n == 90, "R5 bit clock period", n, 90);

        // R6 sync width and period
        pv = 1'b1;
        while (!(!pv && fsync_out)) begin pv = fsync_out; @(negedge clk); end
        n = 0;
        while (fsync_out) begin @(negedge clk); n++; end
        chk(n == 720, "R6 sync high width", n, 720);
        pv = 1'b0;
        while (!(!pv && fsync_out)) begin pv = fsync_out; @(negedge clk); n++; end
        chk(n == 2250, "R6 sync period", n, 2250);

        // R7 frames on generated timing
        int_frame(8'hA5, 8'h3C, 8'h81, 8'h7E);
        int_frame(8'h00, 8'hFF, 8'hFF, 8'h00);

        // R8 power-down
        sel_int = 1'b0;
        pwr_dn = 1'b1;
        repeat (2) @(negedge clk);
        bad = 0; l0 = ld_cnt;
        for (int c = 0; c < 400; c++) begin
            ext_bclk = c[3]; ext_fsync = c[6];
            @(negedge clk);
            if (bclk_out || fsync_out || sout_oe || rout_oe) bad++;
        end
        chk(bad == 0, "R8 outputs quiet", bad, 0);
        chk(ld_cnt == l0, "R8 no strobe", ld_cnt - l0, 0);
        ext_bclk = 1'b0; ext_fsync = 1'b0;
        pwr_dn = 1'b0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(sin_word == 0 && ld_n, "R9 re-reset state", sin_word, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        ext_frame(8'h12, 8'h34, 8'h56, 8'h78);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule